// File: doc/BRIEF.md
# Zero-Current Disconnect Detector

This block watches a powered port for removal of its load. Once the port has reached power-good and the detector is enabled, an undercurrent comparator flag is sampled on every millisecond tick. Undercurrent has to build up a long qualification time before the block declares the load gone. A short return of current is treated as a glitch: it still counts toward the qualification time. Only a sustained return of current, lasting the deglitch time, restarts the qualification.

When qualification completes, the block latches a fault. It asks for the port switch to open and drives its active-low zero-current flag low. How the fault is released depends on the detection mode. With detection enabled, the fault raises a one-cycle request for a new detection sequence and clears when a detection-success strobe arrives. With detection disabled, the fault clears only after the enable input has been seen low and then high again.

Top module: `zcDisconnect`

## Requirements
- R1: After reset, zcN is 1, switchOff is 0 and redetectReq is 0.
- R2: No fault forms unless zcEnable and powerGood are both high. Undercurrent ticks with either input low leave switchOff at 0.
- R3: Under continuous undercurrent, the fault appears on the QUAL_MS-th tick counted from the first undercurrent tick. switchOff is visible in the clock cycle after that tick.
- R4: DEGLITCH_MS consecutive ticks without undercurrent, seen during qualification, clear the qualification count. A further QUAL_MS undercurrent ticks are then needed. If the count reaches QUAL_MS during those ticks, the fault forms first.
- R5: A run of fewer than DEGLITCH_MS ticks without undercurrent neither clears nor pauses qualification. Each such tick adds to the count.
- R6: On a fault, switchOff goes to 1 and zcN goes to 0, and both stay there until a release event.
- R7: With detDisable at 0, redetectReq is high for exactly one cycle, in the same cycle that switchOff first reads 1. The fault clears in the cycle after a detectOk strobe.
- R8: With detDisable at 1, no redetectReq is raised and detectOk has no effect. The fault clears only after portEnable has been sampled 0 and then sampled 1.
- R9: powerGood going low clears both counters without raising a fault. A later undercurrent run needs the full QUAL_MS ticks.
- R10: While zcEnable is 0, zcN reads 1, even if a fault is still latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| msTick | input | 1 | One-cycle millisecond tick |
| zcEnable | input | 1 | Detector enable |
| powerGood | input | 1 | Port power-good state |
| underCurrent | input | 1 | Comparator flag: load current below the threshold |
| detDisable | input | 1 | 1 = detection disabled mode |
| detectOk | input | 1 | Strobe: a valid device has been detected |
| portEnable | input | 1 | Port enable input |
| zcN | output | 1 | Zero-current flag, active low (1 = inactive) |
| switchOff | output | 1 | Request to open the port switch |
| redetectReq | output | 1 | One-cycle request for a new detection sequence |

## Verification
Two events can fall on the same tick: the deglitch clear and the end of qualification. This happens when the current returns late in the window, so that the count reaches QUAL_MS on a tick without undercurrent before the deglitch run has finished. The bench sweeps every start position and every length of the current-return gap over a reduced window. For each case it computes the tick on which switchOff must rise and compares switchOff after every tick. Cases where the deglitch run completes too late must fault at QUAL_MS, not at the restarted count.

// File: rtl/zcDetPkg.sv
package zcDetPkg;
  typedef struct packed {
    logic count;   // a millisecond tick is being applied
    logic under;   // undercurrent seen on this tick
    logic clear;   // detector disarmed: zero both counters
  } zcStrobeT;
endpackage

// File: rtl/zcDetDatapath.sv
module zcDetDatapath
  import zcDetPkg::*;
#(
  parameter int QUAL_MS     = 350,
  parameter int DEGLITCH_MS = 10
) (
  input  logic     clk,
  input  logic     rstN,
  input  zcStrobeT strobe,
  output logic     qualHit
);
  localparam int QW = $clog2(QUAL_MS + 1);
  localparam int DW = $clog2(DEGLITCH_MS + 1);

  logic [QW-1:0] qualCnt, qualNext;
  logic [DW-1:0] aboveCnt, aboveNext;

  always_comb begin
    qualNext  = qualCnt;
    aboveNext = aboveCnt;
    qualHit   = 1'b0;
    if (strobe.clear) begin
      qualNext  = '0;
      aboveNext = '0;
    end else if (strobe.count) begin
      if (strobe.under) begin
        aboveNext = '0;
        qualNext  = qualCnt + 1'b1;
      end else if (qualCnt != '0) begin
        if (aboveCnt == DW'(DEGLITCH_MS - 1)) begin
          qualNext  = '0;
          aboveNext = '0;
        end else begin
          aboveNext = aboveCnt + 1'b1;
          qualNext  = qualCnt + 1'b1;
        end
      end
      qualHit = (qualNext == QW'(QUAL_MS));
      if (qualHit) begin
        qualNext  = '0;
        aboveNext = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualCnt  <= '0;
      aboveCnt <= '0;
    end else begin
      qualCnt  <= qualNext;
      aboveCnt <= aboveNext;
    end
  end

  // R3
  qual_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    qualCnt < QW'(QUAL_MS));

  // R5
  above_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    aboveCnt < DW'(DEGLITCH_MS));

  // R4
  deglitch_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.count && !strobe.under && !strobe.clear) &&
     $past(aboveCnt) == DW'(DEGLITCH_MS - 1)) |-> (qualCnt == '0 && aboveCnt == '0));

  // R9
  disarm_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (qualCnt == '0 && aboveCnt == '0));
endmodule

// File: rtl/zcDetControl.sv
module zcDetControl
  import zcDetPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     msTick,
  input  logic     zcEnable,
  input  logic     powerGood,
  input  logic     underCurrent,
  input  logic     detDisable,
  input  logic     detectOk,
  input  logic     portEnable,
  input  logic     qualHit,
  output zcStrobeT strobe,
  output logic     zcN,
  output logic     switchOff,
  output logic     redetectReq
);
  logic faulted;
  logic sawLow;
  logic armed;

  assign armed        = zcEnable && powerGood && !faulted;
  assign strobe.clear = !armed;
  assign strobe.count = msTick;
  assign strobe.under = underCurrent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faulted     <= 1'b0;
      sawLow      <= 1'b0;
      redetectReq <= 1'b0;
    end else begin
      redetectReq <= 1'b0;
      if (qualHit) begin
        faulted     <= 1'b1;
        sawLow      <= 1'b0;
        redetectReq <= !detDisable;
      end else if (faulted) begin
        if (!detDisable) begin
          if (detectOk) faulted <= 1'b0;
        end else if (!portEnable) begin
          sawLow <= 1'b1;
        end else if (sawLow) begin
          faulted <= 1'b0;
          sawLow  <= 1'b0;
        end
      end
    end
  end

  assign switchOff = faulted;
  assign zcN       = !(faulted && zcEnable);

  // R2
  arm_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(switchOff) |-> $past(zcEnable && powerGood));

  // R7
  redetect_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    redetectReq |-> (switchOff && !$past(detDisable) && !$past(switchOff)));

  // R7
  release_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(switchOff) && !$past(detDisable)) |-> $past(detectOk));

  // R8
  release_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(switchOff) && $past(detDisable)) |-> $past(portEnable));
endmodule

// File: rtl/zcDisconnect.sv
module zcDisconnect
  import zcDetPkg::*;
#(
  parameter int QUAL_MS     = 350,
  parameter int DEGLITCH_MS = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic zcEnable,
  input  logic powerGood,
  input  logic underCurrent,
  input  logic detDisable,
  input  logic detectOk,
  input  logic portEnable,
  output logic zcN,
  output logic switchOff,
  output logic redetectReq
);
  zcStrobeT strobe;
  logic     qualHit;

  zcDetDatapath #(.QUAL_MS(QUAL_MS), .DEGLITCH_MS(DEGLITCH_MS)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .qualHit(qualHit)
  );

  zcDetControl u_ctrl (
    .clk(clk), .rstN(rstN), .msTick(msTick), .zcEnable(zcEnable),
    .powerGood(powerGood), .underCurrent(underCurrent), .detDisable(detDisable),
    .detectOk(detectOk), .portEnable(portEnable), .qualHit(qualHit),
    .strobe(strobe), .zcN(zcN), .switchOff(switchOff), .redetectReq(redetectReq)
  );
endmodule

// File: tb/zcDisconnect_tb.sv
module zcDisconnect_tb;
  localparam int Q = 12;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0, zcEnable = 1'b1, powerGood = 1'b0, underCurrent = 1'b0;
  logic detDisable = 1'b0, detectOk = 1'b0, portEnable = 1'b1;
  logic zcN, switchOff, redetectReq;
  int   nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  zcDisconnect #(.QUAL_MS(Q), .DEGLITCH_MS(D)) u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .zcEnable(zcEnable),
    .powerGood(powerGood), .underCurrent(underCurrent), .detDisable(detDisable),
    .detectOk(detectOk), .portEnable(portEnable),
    .zcN(zcN), .switchOff(switchOff), .redetectReq(redetectReq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doTick(input logic uc);
    @(negedge clk);
    underCurrent = uc;
    msTick = 1'b1;
    @(negedge clk);
    msTick = 1'b0;
  endtask

  task automatic disarmPulse();
    @(negedge clk);
    powerGood = 1'b0;
    @(negedge clk);
    powerGood = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog R3 actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 zcN", zcN, 1);
    chk("R1 switchOff", switchOff, 0);
    chk("R1 redetectReq", redetectReq, 0);
    rstN = 1'b1;

    // R2: powerGood low, long undercurrent never faults
    for (int i = 0; i < 2 * Q; i++) begin
      doTick(1'b1);
      chk("R2 no fault without powerGood", switchOff, 0);
    end
    powerGood = 1'b1;

    // R3/R4/R5/R6/R7: sweep gap start and gap length
    for (int gs = 1; gs < Q; gs++) begin
      for (int gl = 1; gl <= D; gl++) begin
        int expIdx;
        disarmPulse();
        expIdx = (gl < D || gs + D - 1 >= Q) ? Q : gs + D + Q;
        for (int idx = 1; idx <= expIdx; idx++) begin
          doTick((idx > gs && idx <= gs + gl) ? 1'b0 : 1'b1);
          chk(gl < D ? "R5 switchOff per tick" : "R4 switchOff per tick",
              switchOff, (idx == expIdx) ? 1 : 0);
          if (idx == expIdx) begin
            chk("R6 zcN latched low", zcN, 0);
            chk("R7 redetect pulse", redetectReq, 1);
          end
        end
        @(negedge clk);
        chk("R7 redetect one cycle", redetectReq, 0);
        chk("R6 switchOff held", switchOff, 1);
        detectOk = 1'b1;
        @(negedge clk);
        detectOk = 1'b0;
        chk("R7 release switchOff", switchOff, 0);
        chk("R7 release zcN", zcN, 1);
      end
    end

    // R3: plain continuous run after release
    disarmPulse();
    for (int idx = 1; idx <= Q; idx++) begin
      doTick(1'b1);
      chk("R3 continuous", switchOff, idx == Q ? 1 : 0);
    end
    @(negedge clk); detectOk = 1'b1;
    @(negedge clk); detectOk = 1'b0;

    // R8: detection disabled
    detDisable = 1'b1;
    disarmPulse();
    for (int idx = 1; idx <= Q; idx++) begin
      doTick(1'b1);
      chk("R8 fault tick", switchOff, idx == Q ? 1 : 0);
      chk("R8 no redetect", redetectReq, 0);
    end
    @(negedge clk); detectOk = 1'b1;
    @(negedge clk); detectOk = 1'b0;
    chk("R8 detectOk ignored", switchOff, 1);
    @(negedge clk);
    chk("R8 enable high alone", switchOff, 1);
    portEnable = 1'b0;
    @(negedge clk);
    chk("R8 enable low holds", switchOff, 1);
    chk("R8 zcN low", zcN, 0);
    portEnable = 1'b1;
    @(negedge clk);
    chk("R8 toggle releases", switchOff, 0);
    chk("R8 zcN released", zcN, 1);
    detDisable = 1'b0;

    // R9: powerGood drop clears counters
    disarmPulse();
    for (int idx = 1; idx < Q; idx++) doTick(1'b1);
    chk("R9 before drop", switchOff, 0);
    disarmPulse();
    for (int idx = 1; idx <= Q; idx++) begin
      doTick(1'b1);
      chk("R9 full window after drop", switchOff, idx == Q ? 1 : 0);
    end

    // R10: zcEnable low masks flag while fault latched
    @(negedge clk); zcEnable = 1'b0;
    @(negedge clk);
    chk("R10 zcN inactive", zcN, 1);
    chk("R10 fault kept", switchOff, 1);
    detectOk = 1'b1;
    @(negedge clk); detectOk = 1'b0;
    for (int i = 0; i < 2 * Q; i++) begin
      doTick(1'b1);
      chk("R10 zcN inactive", zcN, 1);
      chk("R2 no fault with enable low", switchOff, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule